// File: doc/BRIEF.md
# Interleaved Slice Sequencer and Result Selector

This block coordinates a bank of parallel conversion slices that share one input clock. Each slice needs a full frame of clock cycles to produce a result, so the slices are launched in turn: on every cycle exactly one slice receives a frame-start strobe. Starts rotate through the bank and repeat once per frame. In each slice's frame, the input is sampled in the fourth cycle and the 13-bit result is handed over at the end of the seventeenth cycle.

A selector follows the same rotation with a fixed delay. On each cycle it picks the slice whose hand-over slot is current. That result is formatted into a registered 12-bit straight-binary word with an overrange flag, so output words leave in the order the samples were taken. A result above the 12-bit full-scale code sets the flag and forces every data bit to one. A small controller has three states. `SEQ_IDLE` is held during reset. It moves to `SEQ_PRIME` on the first edge after reset, and the rotation starts there. After sixteen cycles it moves to `SEQ_STREAM`, where the output register loads the selected result every cycle. Until then the output is marked invalid.

Top module: `ilv_seq_top`

## Requirements
- R1: While running, exactly one bit of `slice_start` is high in every cycle. During reset, and in the single `SEQ_IDLE` cycle after reset, all bits are low.
- R2: The first strobe after the `SEQ_IDLE` cycle goes to slice 0. Each following cycle strobes the next slice index, and index 17 wraps to 0. Slice k is therefore strobed in cycle k modulo 18, counted from the first running cycle (cycle 0).
- R3: A slice started in cycle t must present its result with its valid bit in cycle t+16. That result appears on the outputs in cycle t+17, which is 14 cycles after the slice's sampling cycle t+3.
- R4: `out_valid` is 1 in cycle c+1 exactly when the slice scheduled for hand-over in cycle c has its valid bit high in cycle c. Valid bits and result buses of all other slices have no effect on the outputs.
- R5: A selected result of 4095 or less gives `out_ovr` = 0 and `out_data` equal to the low 12 bits of the result, in straight binary (0 maps to 0, 4095 maps to all ones).
- R6: A selected result of 4096 or more gives `out_ovr` = 1 and `out_data` = 12'hFFF, for as long as such results keep arriving.
- R7: Whenever `out_valid` is 0, `out_data` is 0 and `out_ovr` is 0.
- R8: From reset release until cycle 16, `out_valid` stays 0 even if slices drive valid bits. The first valid word can appear no earlier than cycle 17.
- R9: While `rst_n` is low, `slice_start`, `out_data`, `out_ovr` and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| slice_res | input | 234 | 18 results of 13 bits each; slice k occupies bits [13k+12:13k] |
| slice_vld | input | 18 | Result-valid bit of each slice, bit k for slice k |
| slice_start | output | 18 | One-hot frame-start strobes, bit k for slice k |
| out_data | output | 12 | Registered straight-binary output word |
| out_ovr | output | 1 | Registered overrange flag |
| out_valid | output | 1 | Output word holds a delivered result |

## Verification
The assertions assume that the slices obey the schedule the block sets. A slice strobed in cycle t may only claim its hand-over through a valid bit in cycle t+16. A valid output is therefore taken to follow a cycle in which some slice valid bit was high. The bench's slice models use the bench's own copy of the rotation to place each genuine result in its slot, and to draw sample values from a seeded random stream mixed with codes at 0, 4094, 4095, 4096 and 8191. Stray valid pulses with random data are also driven, on other slices and before streaming begins. They are allowed to reach the selector inputs but never to reach the output.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_PRIME  = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int CAP_OFS = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic run,
    output logic capture_en
);

    localparam int CNT_W = $clog2(CAP_OFS + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(CAP_OFS - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] fill_q, fill_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            SEQ_IDLE: begin
                state_d = SEQ_PRIME;
                fill_d  = '0;
            end
            SEQ_PRIME: begin
                if (fill_q == FILL_LAST) begin
                    state_d = SEQ_STREAM;
                end else begin
                    fill_d = fill_q + 1'b1;
                end
            end
            SEQ_STREAM: begin
                state_d = SEQ_STREAM;
            end
            default: begin
                state_d = SEQ_IDLE;
                fill_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        capture_en = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   ;
            SEQ_PRIME:  run = 1'b1;
            SEQ_STREAM: begin
                run        = 1'b1;
                capture_en = 1'b1;
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/ilv_phase.sv
module ilv_phase #(
    parameter int N_SLICES = 18,
    parameter int CAP_OFS  = 16,
    parameter int IDX_W    = $clog2(N_SLICES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    output logic [N_SLICES-1:0] start,
    output logic [IDX_W-1:0]    sel_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLICES - 1);
    localparam logic [IDX_W-1:0] OFS_BACK = IDX_W'(CAP_OFS);
    localparam logic [IDX_W-1:0] OFS_WRAP = IDX_W'(N_SLICES - CAP_OFS);

    logic [IDX_W-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (run) begin
            ph_q <= (ph_q == LAST_IDX) ? '0 : ph_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_SLICES; g++) begin : g_strobe
        assign start[g] = run && (ph_q == IDX_W'(g));
    end

    // slice whose hand-over slot is the current cycle
    always_comb begin
        if (ph_q >= OFS_BACK) begin
            sel_idx = ph_q - OFS_BACK;
        end else begin
            sel_idx = ph_q + OFS_WRAP;
        end
    end

endmodule

// File: rtl/ilv_select.sv
module ilv_select #(
    parameter int N_SLICES = 18,
    parameter int RES_W    = 13,
    parameter int IDX_W    = $clog2(N_SLICES)
) (
    input  logic [N_SLICES*RES_W-1:0] slice_res,
    input  logic [N_SLICES-1:0]       slice_vld,
    input  logic [IDX_W-1:0]          sel_idx,
    output logic [RES_W-1:0]          sel_res,
    output logic                      sel_vld
);

    always_comb begin
        sel_res = '0;
        sel_vld = 1'b0;
        for (int i = 0; i < N_SLICES; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_res = slice_res[i*RES_W +: RES_W];
                sel_vld = slice_vld[i];
            end
        end
    end

endmodule

// File: rtl/ilv_format.sv
module ilv_format #(
    parameter int RES_W = 13,
    parameter int OUT_W = RES_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic [RES_W-1:0] sel_res,
    input  logic             sel_vld,
    output logic [OUT_W-1:0] out_data,
    output logic             out_ovr,
    output logic             out_valid
);

    localparam logic [RES_W-1:0] FULL_CODE = RES_W'((1 << OUT_W) - 1);

    logic             above_full;
    logic             take;
    logic [OUT_W-1:0] data_d;

    assign above_full = sel_res > FULL_CODE;
    assign take       = capture_en && sel_vld;

    always_comb begin
        if (!take) begin
            data_d = '0;
        end else if (above_full) begin
            data_d = '1;
        end else begin
            data_d = sel_res[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_ovr   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_data  <= data_d;
            out_ovr   <= take && above_full;
            out_valid <= take;
        end
    end

endmodule

// File: rtl/ilv_seq_top.sv
module ilv_seq_top #(
    parameter int N_SLICES   = 18,
    parameter int RES_W      = 13,
    parameter int SAMPLE_OFS = 3,
    parameter int LATENCY    = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLICES*RES_W-1:0] slice_res,
    input  logic [N_SLICES-1:0]       slice_vld,
    output logic [N_SLICES-1:0]       slice_start,
    output logic [RES_W-2:0]          out_data,
    output logic                      out_ovr,
    output logic                      out_valid
);

    localparam int OUT_W   = RES_W - 1;
    localparam int CAP_OFS = SAMPLE_OFS + LATENCY - 1;
    localparam int IDX_W   = $clog2(N_SLICES);

    logic             run;
    logic             capture_en;
    logic [IDX_W-1:0] sel_idx;
    logic [RES_W-1:0] sel_res;
    logic             sel_vld;

    ilv_ctrl #(
        .CAP_OFS (CAP_OFS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .capture_en (capture_en)
    );

    ilv_phase #(
        .N_SLICES (N_SLICES),
        .CAP_OFS  (CAP_OFS),
        .IDX_W    (IDX_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .start   (slice_start),
        .sel_idx (sel_idx)
    );

    ilv_select #(
        .N_SLICES (N_SLICES),
        .RES_W    (RES_W),
        .IDX_W    (IDX_W)
    ) u_select (
        .slice_res (slice_res),
        .slice_vld (slice_vld),
        .sel_idx   (sel_idx),
        .sel_res   (sel_res),
        .sel_vld   (sel_vld)
    );

    ilv_format #(
        .RES_W (RES_W),
        .OUT_W (OUT_W)
    ) u_format (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .sel_res    (sel_res),
        .sel_vld    (sel_vld),
        .out_data   (out_data),
        .out_ovr    (out_ovr),
        .out_valid  (out_valid)
    );

endmodule

// File: rtl/ilv_seq_chk.sv
module ilv_seq_chk #(
    parameter int N_SLICES = 18,
    parameter int OUT_W    = 12,
    parameter int CAP_OFS  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_SLICES-1:0] slice_start,
    input logic [N_SLICES-1:0] slice_vld,
    input logic [OUT_W-1:0]    out_data,
    input logic                out_ovr,
    input logic                out_valid
);

    localparam int EDGE_MIN = CAP_OFS + 2;
    localparam int AGE_W    = $clog2(EDGE_MIN + 1) + 1;
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(EDGE_MIN);

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != AGE_SAT) begin
            age_q <= age_q + 1'b1;
        end
    end

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slice_start)); // R1

    AST_START_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_start != '0) |=> (slice_start != '0)); // R1

    AST_START_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_start != '0) |=>
            (slice_start == {$past(slice_start[N_SLICES-2:0]), $past(slice_start[N_SLICES-1])})); // R2

    AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(slice_vld != '0)); // R4

    AST_OVR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovr |-> (out_data == '1)); // R6

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0 && !out_ovr)); // R7

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (age_q >= AGE_SAT)); // R8

endmodule

bind ilv_seq_top ilv_seq_chk #(
    .N_SLICES (N_SLICES),
    .OUT_W    (OUT_W),
    .CAP_OFS  (CAP_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slice_start (slice_start),
    .slice_vld   (slice_vld),
    .out_data    (out_data),
    .out_ovr     (out_ovr),
    .out_valid   (out_valid)
);

// File: tb/tb_ilv_seq_top.sv
module tb_ilv_seq_top;

    localparam int N    = 18;
    localparam int RW   = 13;
    localparam int LAT  = 14;
    localparam int CAP  = 16;
    localparam int NCYC = 400;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N*RW-1:0] res_bus;
    logic [N-1:0]    vld_bus;
    logic [N-1:0]    slice_start;
    logic [RW-2:0]   out_data;
    logic            out_ovr;
    logic            out_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [RW-1:0] samp [NCYC];
    bit            drop [NCYC];

    always #5 clk = ~clk;

    ilv_seq_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slice_res   (res_bus),
        .slice_vld   (vld_bus),
        .slice_start (slice_start),
        .out_data    (out_data),
        .out_ovr     (out_ovr),
        .out_valid   (out_valid)
    );

    function automatic int exp_data(int v);
        return (v > 4095) ? 4095 : (v & 4095);
    endfunction

    function automatic int exp_ovr(int v);
        return (v > 4095) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic drive(int c);
        res_bus = '0;
        vld_bus = '0;
        if (c < CAP) begin
            // stray pulses before streaming, R8
            int k = $urandom_range(N - 1, 0);
            vld_bus[k] = 1'b1;
            res_bus[k*RW +: RW] = RW'($urandom_range(8191, 0));
        end else begin
            int s = (c - CAP) % N;
            if (!drop[c]) begin
                vld_bus[s] = 1'b1;
                res_bus[s*RW +: RW] = samp[c - CAP + 3];
            end
            if ($urandom_range(1, 0) == 1) begin
                // pulse on a slice outside its slot, R4
                int k = (s + 1 + $urandom_range(N - 2, 0)) % N;
                vld_bus[k] = 1'b1;
                res_bus[k*RW +: RW] = RW'($urandom_range(8191, 0));
            end
        end
    endtask

    task automatic check_cycle(int c);
        chk("R1", "one start per cycle", $countones(slice_start), 1);
        chk("R2", "start rotation", int'(slice_start), 1 << (c % N));
        if (c <= CAP) begin
            chk("R8", "valid before first hand-over", int'(out_valid), 0);
            chk("R8", "data before first hand-over", int'(out_data), 0);
        end else if (drop[c-1]) begin
            chk("R4", "valid with missing result", int'(out_valid), 0);
            chk("R7", "data when invalid", int'(out_data), 0);
            chk("R7", "ovr when invalid", int'(out_ovr), 0);
        end else begin
            int v = int'(samp[c - LAT]);
            chk("R4", "valid on delivered slot", int'(out_valid), 1);
            if (v > 4095) begin
                chk("R3 R6", "clamped data", int'(out_data), exp_data(v));
                chk("R6", "ovr flag", int'(out_ovr), exp_ovr(v));
            end else begin
                chk("R3 R5", "binary data", int'(out_data), exp_data(v));
                chk("R5", "ovr flag", int'(out_ovr), exp_ovr(v));
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int c = 0; c < NCYC; c++) begin
            samp[c] = RW'($urandom_range(8191, 0));
            drop[c] = ($urandom_range(7, 0) == 0);
        end
        samp[3]  = 13'd0;
        samp[4]  = 13'd4095;
        samp[5]  = 13'd4096;
        samp[6]  = 13'd8191;
        samp[7]  = 13'd4094;
        samp[8]  = 13'd4097;
        samp[9]  = 13'd1;
        samp[10] = 13'd2048;
        for (int c = CAP; c < CAP + 12; c++) drop[c] = 1'b0;
        drop[40] = 1'b1;

        rst_n   = 1'b0;
        res_bus = '0;
        vld_bus = '1;
        repeat (3) @(posedge clk);
        #5;
        chk("R9", "start in reset", int'(slice_start), 0);
        chk("R9", "data in reset", int'(out_data), 0);
        chk("R9", "ovr in reset", int'(out_ovr), 0);
        chk("R9", "valid in reset", int'(out_valid), 0);

        @(posedge clk);
        #1;
        rst_n   = 1'b1;
        vld_bus = '0;
        #4;
        chk("R1", "no start in idle cycle", int'(slice_start), 0);

        @(posedge clk);
        for (int c = 0; c < NCYC; c++) begin
            #1;
            drive(c);
            #4;
            check_cycle(c);
            @(posedge clk);
        end
        finish_run();
    end

endmodule